// File: doc/BRIEF.md
# Interrupt redirection table controller

This block routes external interrupt lines to interrupt messages. Each input line passes through a two-stage sampler. A polarity bit sets whether the line is active high or active low. A trigger bit then selects edge or level detection. Each line has its own routing entry, which supplies the outgoing message: vector number, delivery type, destination interpretation and destination. Only one message is shown on the valid/ready output port at a time. When several lines are waiting, the lowest line number goes first.

Software reaches the block through a 32-bit register bus with only two visible registers: a selector and a data window. The value written to the selector chooses which internal word the window reaches. Internal word 0 is the router identifier. Routing entries follow from word 0x10, two words per line.

Level-triggered lines use an acknowledge handshake. Once a level message is accepted, the line is blocked. It stays blocked until an end-of-interrupt strobe arrives carrying the same vector. Edge-triggered lines queue one request per active edge.

Top module: `irq_router_top`

## Requirements
- R1: A bus write at byte address 0x00 loads the 8-bit selector, and a read there returns it in bits 7:0. Reads and writes at byte address 0x10 reach the internal word picked by the selector. Selector values with no internal word read as 0 and ignore writes.
- R2: Internal word 0 keeps the identifier in bits 31:24. That field is writable and reads back, and all other bits of the word read 0.
- R3: Line n has its low word at internal word 0x10+2n and its high word at 0x11+2n. The low word fields are: vector in 7:0, delivery type in 10:8, destination interpretation in 11 (0 physical, 1 logical), status in 12 (read-only), polarity in 13, acknowledge-hold in 14 (read-only), trigger in 15 and mask in 16. The high word holds the destination in bits 31:24. Every other bit reads 0.
- R4: After reset, the selector is 0, `msg_valid` is 0, and every entry reads 0x0001_0000 (mask set, all other fields 0).
- R5: A polarity bit of 1 makes a low input level the active state. A polarity bit of 0 makes a high level active.
- R6: With trigger 0 (edge), each change of a line from inactive to active queues exactly one message. A line that stays active sends nothing more.
- R7: With trigger 1 (level), an active unmasked line sends a message. Acceptance sets acknowledge-hold, and no further message is sent until an end-of-interrupt strobe with a matching vector clears it. If the acceptance and the end-of-interrupt strobe fall in the same cycle, the hold is set.
- R8: A masked line never sends a message. Setting the mask discards a queued edge request and withdraws a message that is being shown but has not been accepted.
- R9: The status bit reads 1 while a line has a request waiting or being shown, and reads 0 otherwise.
- R10: Pending lines are served lowest line number first. An unaccepted message stays valid with unchanged fields unless its line becomes masked.
- R11: A message carries the entry's vector, delivery type, destination interpretation and destination. The delivery type encodings are fixed 0, lowest priority 1, system management 2, non-maskable 4, init 5 and external 7.
- R12: Read data appears on `bus_rdata` one clock after `bus_rd`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte address (0x00 selector, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NL | External interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery type |
| msg_dstmode | output | 1 | Destination interpretation |
| msg_dest | output | 8 | Destination |

## Verification
Two pairs of events can land on the same clock edge. The first is acceptance of a level message and an end-of-interrupt strobe for the same vector. The bench provokes this by raising `msg_ready` and the strobe together while the message is shown. It then expects the hold bit to read back 1 and no new message to appear. The second is a mask write and a message that is shown but not yet accepted. The bench writes the mask while `msg_ready` is low and expects the message to be withdrawn on the following edge. A cycle-accurate behavioural model judges every clock in both cases.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMGMT  = 3'd2,
    DM_NONMSK = 3'd4,
    DM_INIT   = 3'd5,
    DM_EXTERN = 3'd7
  } dmode_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dstmode;
    logic [2:0] dmode;
    logic [7:0] vector;
  } rte_cfg_t;

  localparam int unsigned TBL_BASE = 16;
  localparam int unsigned ID_WORD  = 0;

  localparam rte_cfg_t RTE_RESET = '{dest: 8'h00, mask: 1'b1, trig: 1'b0,
                                     pol: 1'b0, dstmode: 1'b0, dmode: 3'd0,
                                     vector: 8'h00};

endpackage

// File: rtl/irq_line_front.sv
module irq_line_front #(
  parameter int NL = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] pol,
  input  logic [NL-1:0] trig,
  output logic [NL-1:0] lvl_on,
  output logic [NL-1:0] edge_hit
);

  logic [NL-1:0] samp_q;
  logic [NL-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      samp_q <= irq_in;
      prev_q <= samp_q;
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic now_on;
    logic was_on;
    assign now_on      = samp_q[i] ^ pol[i];
    assign was_on      = prev_q[i] ^ pol[i];
    assign lvl_on[i]   = trig[i] & now_on;
    assign edge_hit[i] = ~trig[i] & now_on & ~was_on;
  end

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NL = 24,
  parameter int EW = $clog2(NL)
) (
  input  logic [NL-1:0] req,
  output logic [NL-1:0] grant,
  output logic          any,
  output logic [EW-1:0] win
);

  assign grant = req & (~req + NL'(1));
  assign any   = |req;

  always_comb begin
    win = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (req[i]) win = EW'(i);
    end
  end

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_router_pkg::*;
#(
  parameter int NL = 24,
  parameter int EW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_lo,
  input  logic          we_hi,
  input  logic [EW-1:0] wr_ent,
  input  rte_cfg_t      wr_cfg,
  input  logic [NL-1:0] lvl_on,
  input  logic [NL-1:0] edge_hit,
  input  logic          acc,
  input  logic [EW-1:0] acc_ent,
  input  logic          eoi_valid,
  input  logic [7:0]    eoi_vector,
  input  logic [EW-1:0] rd_ent,
  input  logic          rd_hi,
  output logic [31:0]   rd_word,
  input  logic [EW-1:0] pick_ent,
  output rte_cfg_t      pick_cfg,
  output logic [NL-1:0] mask_vec,
  output logic [NL-1:0] pol_vec,
  output logic [NL-1:0] trig_vec,
  output logic [NL-1:0] rirr_vec,
  output logic [NL-1:0] req_vec
);

  rte_cfg_t ent_arr [NL];

  for (genvar i = 0; i < NL; i++) begin : g_ent
    rte_cfg_t ent_q;
    logic     pend_q;
    logic     hold_q;
    logic     hit_w;
    logic     hit_acc;
    logic     hit_eoi;

    assign hit_w   = (wr_ent == EW'(i));
    assign hit_acc = acc && (acc_ent == EW'(i));
    assign hit_eoi = eoi_valid && (eoi_vector == ent_q.vector) && ent_q.trig;

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q <= RTE_RESET;
      end else begin
        if (we_lo && hit_w) begin
          ent_q.vector  <= wr_cfg.vector;
          ent_q.dmode   <= wr_cfg.dmode;
          ent_q.dstmode <= wr_cfg.dstmode;
          ent_q.pol     <= wr_cfg.pol;
          ent_q.trig    <= wr_cfg.trig;
          ent_q.mask    <= wr_cfg.mask;
        end
        if (we_hi && hit_w) begin
          ent_q.dest <= wr_cfg.dest;
        end
      end
    end

    // edge request: masked lines drop it, acceptance consumes it, a new edge wins
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
        hold_q <= 1'b0;
      end else begin
        pend_q <= ~ent_q.mask & (edge_hit[i] | (pend_q & ~hit_acc));
        hold_q <= (hit_acc & ent_q.trig) | (hold_q & ~hit_eoi);
      end
    end

    assign ent_arr[i]  = ent_q;
    assign req_vec[i]  = pend_q | (lvl_on[i] & ~ent_q.mask & ~hold_q);
    assign mask_vec[i] = ent_q.mask;
    assign pol_vec[i]  = ent_q.pol;
    assign trig_vec[i] = ent_q.trig;
    assign rirr_vec[i] = hold_q;
  end

  always_comb begin
    rd_word = '0;
    if (int'(rd_ent) < NL) begin
      if (rd_hi) begin
        rd_word = {ent_arr[rd_ent].dest, 24'h0};
      end else begin
        rd_word = {15'h0, ent_arr[rd_ent].mask, ent_arr[rd_ent].trig,
                   rirr_vec[rd_ent], ent_arr[rd_ent].pol, req_vec[rd_ent],
                   ent_arr[rd_ent].dstmode, ent_arr[rd_ent].dmode,
                   ent_arr[rd_ent].vector};
      end
    end
  end

  assign pick_cfg = ent_arr[pick_ent];

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NL = 24,
  parameter int AW = 5,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NL-1:0] irq_in,
  input  logic          eoi_valid,
  input  logic [7:0]    eoi_vector,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [7:0]    msg_vector,
  output logic [2:0]    msg_dmode,
  output logic          msg_dstmode,
  output logic [7:0]    msg_dest
);

  localparam int EW      = $clog2(NL);
  localparam int TBL_END = int'(TBL_BASE) + 2 * NL;

  logic [IW-1:0] idx_q;
  logic [7:0]    id_q;
  logic [EW-1:0] sel_q;

  logic          at_index;
  logic          at_window;
  logic          in_tbl;
  logic [EW-1:0] tbl_ent;
  logic [31:0]   tbl_word;
  rte_cfg_t      wr_cfg;
  rte_cfg_t      pick_cfg;

  logic [NL-1:0] lvl_on;
  logic [NL-1:0] edge_hit;
  logic [NL-1:0] mask_vec;
  logic [NL-1:0] pol_vec;
  logic [NL-1:0] trig_vec;
  logic [NL-1:0] rirr_vec;
  logic [NL-1:0] req_vec;
  logic [NL-1:0] arb_grant;
  logic          arb_any;
  logic [EW-1:0] arb_win;

  logic          acc;
  logic          drop;
  logic          load;

  assign at_index  = (bus_addr == AW'(0));
  assign at_window = (bus_addr == AW'(16));
  assign in_tbl    = (int'(idx_q) >= int'(TBL_BASE)) && (int'(idx_q) < TBL_END);
  assign tbl_ent   = EW'((32'(idx_q) - 32'(TBL_BASE)) >> 1);

  assign wr_cfg = '{dest: bus_wdata[31:24], mask: bus_wdata[16],
                    trig: bus_wdata[15], pol: bus_wdata[13],
                    dstmode: bus_wdata[11], dmode: bus_wdata[10:8],
                    vector: bus_wdata[7:0]};

  irq_line_front #(.NL(NL)) u_front (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .pol      (pol_vec),
    .trig     (trig_vec),
    .lvl_on   (lvl_on),
    .edge_hit (edge_hit)
  );

  irq_redir_table #(.NL(NL), .EW(EW)) u_table (
    .clk        (clk),
    .rst        (rst),
    .we_lo      (bus_wr && at_window && in_tbl && !idx_q[0]),
    .we_hi      (bus_wr && at_window && in_tbl && idx_q[0]),
    .wr_ent     (tbl_ent),
    .wr_cfg     (wr_cfg),
    .lvl_on     (lvl_on),
    .edge_hit   (edge_hit),
    .acc        (acc),
    .acc_ent    (sel_q),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .rd_ent     (tbl_ent),
    .rd_hi      (idx_q[0]),
    .rd_word    (tbl_word),
    .pick_ent   (arb_win),
    .pick_cfg   (pick_cfg),
    .mask_vec   (mask_vec),
    .pol_vec    (pol_vec),
    .trig_vec   (trig_vec),
    .rirr_vec   (rirr_vec),
    .req_vec    (req_vec)
  );

  irq_prio_arb #(.NL(NL), .EW(EW)) u_arb (
    .req   (req_vec),
    .grant (arb_grant),
    .any   (arb_any),
    .win   (arb_win)
  );

  // selector, identifier and registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      id_q      <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && at_index) idx_q <= bus_wdata[IW-1:0];
      if (bus_wr && at_window && (int'(idx_q) == int'(ID_WORD))) id_q <= bus_wdata[31:24];
      if (bus_rd) begin
        if (at_index) begin
          bus_rdata <= 32'(idx_q);
        end else if (at_window) begin
          if (int'(idx_q) == int'(ID_WORD)) bus_rdata <= {id_q, 24'h0};
          else if (in_tbl)                  bus_rdata <= tbl_word;
          else                              bus_rdata <= '0;
        end else begin
          bus_rdata <= '0;
        end
      end
    end
  end

  // single-slot message stage
  assign acc  = msg_valid && msg_ready;
  assign drop = msg_valid && !msg_ready && mask_vec[sel_q];
  assign load = !msg_valid && arb_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid   <= 1'b0;
      sel_q       <= '0;
      msg_vector  <= '0;
      msg_dmode   <= '0;
      msg_dstmode <= 1'b0;
      msg_dest    <= '0;
    end else if (acc || drop) begin
      msg_valid <= 1'b0;
    end else if (load) begin
      msg_valid   <= 1'b1;
      sel_q       <= arb_win;
      msg_vector  <= pick_cfg.vector;
      msg_dmode   <= pick_cfg.dmode;
      msg_dstmode <= pick_cfg.dstmode;
      msg_dest    <= pick_cfg.dest;
    end
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NL = 24,
  parameter int EW = $clog2(NL)
) (
  input logic          clk,
  input logic          rst,
  input logic          msg_valid,
  input logic          msg_ready,
  input logic [7:0]    msg_vector,
  input logic [7:0]    msg_dest,
  input logic [NL-1:0] grant,
  input logic [NL-1:0] mask_vec,
  input logic [NL-1:0] trig_vec,
  input logic [NL-1:0] rirr_vec,
  input logic [EW-1:0] sel_q
);

  // R10
  hold_msg_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready && !mask_vec[sel_q]
      |=> msg_valid && $stable(msg_vector) && $stable(msg_dest));

  // R10
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R4
  reset_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (&mask_vec) && !msg_valid);

  // R7
  hold_set_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready && trig_vec[sel_q] |=> rirr_vec[sel_q]);

  // R7
  no_held_send_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && trig_vec[sel_q] |-> !rirr_vec[sel_q]);

  // R8
  mask_drop_chk: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready && mask_vec[sel_q] |=> !msg_valid);

endmodule

bind irq_router_top irq_router_chk #(.NL(NL), .EW(EW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_vector (msg_vector),
  .msg_dest   (msg_dest),
  .grant      (arb_grant),
  .mask_vec   (mask_vec),
  .trig_vec   (trig_vec),
  .rirr_vec   (rirr_vec),
  .sel_q      (sel_q)
);

// File: tb/sim_irq_router_top.sv
`timescale 1ns/1ps
module sim_irq_router_top;
  import irq_router_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] irq_in = '0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dmode;
  logic        msg_dstmode;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_router_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dmode(msg_dmode),
    .msg_dstmode(msg_dstmode), .msg_dest(msg_dest));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0]  m_idx, m_id, m_ov, m_odest;
  bit [7:0]  m_vec [24];
  bit [7:0]  m_dst [24];
  bit [2:0]  m_dm  [24];
  bit [2:0]  m_odm;
  bit        m_dsm [24], m_pol [24], m_trig [24], m_mask [24], m_hold [24], m_pend [24];
  bit [23:0] m_s, m_p;
  bit        m_mv, m_odsm;
  int        m_sel;
  bit [31:0] m_rd;

  always @(posedge clk) begin : model
    bit [23:0] req, pn, hn;
    bit acc, ed;
    int ix, e;
    if (rst) begin
      m_idx = 0; m_id = 0; m_mv = 0; m_sel = 0; m_rd = 0; m_s = 0; m_p = 0;
      m_ov = 0; m_odest = 0; m_odm = 0; m_odsm = 0;
      for (int i = 0; i < 24; i++) begin
        m_vec[i] = 0; m_dst[i] = 0; m_dm[i] = 0; m_dsm[i] = 0; m_pol[i] = 0;
        m_trig[i] = 0; m_mask[i] = 1; m_hold[i] = 0; m_pend[i] = 0;
      end
    end else begin
      for (int i = 0; i < 24; i++)
        req[i] = m_pend[i] || (m_trig[i] && (m_s[i] != m_pol[i]) && !m_mask[i] && !m_hold[i]);
      ix = int'(m_idx);
      if (bus_rd) begin
        if (bus_addr == 0) m_rd = {24'h0, m_idx};
        else if (bus_addr == 16) begin
          if (ix == 0) m_rd = {m_id, 24'h0};
          else if (ix >= 16 && ix < 64) begin
            e = (ix - 16) / 2;
            if (ix % 2 == 1) m_rd = {m_dst[e], 24'h0};
            else m_rd = {15'h0, m_mask[e], m_trig[e], m_hold[e], m_pol[e], req[e],
                         m_dsm[e], m_dm[e], m_vec[e]};
          end else m_rd = 0;
        end else m_rd = 0;
      end
      acc = m_mv && msg_ready;
      for (int i = 0; i < 24; i++) begin
        ed = !m_trig[i] && (m_s[i] != m_pol[i]) && (m_p[i] == m_pol[i]);
        pn[i] = !m_mask[i] && (ed || (m_pend[i] && !(acc && m_sel == i)));
        hn[i] = (acc && m_sel == i && m_trig[i]) ||
                (m_hold[i] && !(eoi_valid && eoi_vector == m_vec[i] && m_trig[i]));
      end
      if (acc) m_mv = 0;
      else if (m_mv && m_mask[m_sel]) m_mv = 0;
      else if (!m_mv && req != 0) begin
        for (int i = 23; i >= 0; i--) if (req[i]) m_sel = i;
        m_mv = 1; m_ov = m_vec[m_sel]; m_odm = m_dm[m_sel];
        m_odsm = m_dsm[m_sel]; m_odest = m_dst[m_sel];
      end
      for (int i = 0; i < 24; i++) begin m_pend[i] = pn[i]; m_hold[i] = hn[i]; end
      if (bus_wr) begin
        if (bus_addr == 0) m_idx = bus_wdata[7:0];
        else if (bus_addr == 16) begin
          if (ix == 0) m_id = bus_wdata[31:24];
          else if (ix >= 16 && ix < 64) begin
            e = (ix - 16) / 2;
            if (ix % 2 == 1) m_dst[e] = bus_wdata[31:24];
            else begin
              m_vec[e] = bus_wdata[7:0]; m_dm[e] = bus_wdata[10:8];
              m_dsm[e] = bus_wdata[11]; m_pol[e] = bus_wdata[13];
              m_trig[e] = bus_wdata[15]; m_mask[e] = bus_wdata[16];
            end
          end
        end
      end
      m_p = m_s; m_s = irq_in;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(msg_valid === m_mv, "R10 msg_valid vs model", 32'(msg_valid), 32'(m_mv));
      if (m_mv) begin
        chk(msg_vector === m_ov, "R11 msg_vector vs model", 32'(msg_vector), 32'(m_ov));
        chk(msg_dmode === m_odm, "R11 msg_dmode vs model", 32'(msg_dmode), 32'(m_odm));
        chk(msg_dstmode === m_odsm, "R11 msg_dstmode vs model", 32'(msg_dstmode), 32'(m_odsm));
        chk(msg_dest === m_odest, "R11 msg_dest vs model", 32'(msg_dest), 32'(m_odest));
      end
      chk(bus_rdata === m_rd, "R12 bus_rdata vs model", bus_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic reg_write(input logic [7:0] ix, input logic [31:0] d);
    bus_write(5'h00, {24'h0, ix});
    bus_write(5'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] ix, output logic [31:0] d);
    bus_write(5'h00, {24'h0, ix});
    bus_read(5'h10, d);
  endtask

  function automatic logic [31:0] lo(input logic [7:0] v, input logic [2:0] dm,
                                     input bit dsm, input bit pol, input bit trig, input bit mask);
    return {15'h0, mask, trig, 1'b0, pol, 1'b0, dsm, dm, v};
  endfunction

  task automatic wait_valid(input int maxc);
    for (int i = 0; i < maxc && !msg_valid; i++) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk); msg_ready = 1;
    @(negedge clk); msg_ready = 0;
  endtask

  logic [31:0] d;

  initial begin
    cycles(4);
    rst = 0;
    @(negedge clk);
    // R4 reset state
    chk(msg_valid === 1'b0, "R4 no message after reset", 32'(msg_valid), 0);
    bus_read(5'h00, d); chk(d == 0, "R4 selector reset", d, 0);
    reg_read(8'h10, d); chk(d == 32'h0001_0000, "R4 entry 0 reset", d, 32'h0001_0000);
    reg_read(8'h3E, d); chk(d == 32'h0001_0000, "R4 entry 23 reset", d, 32'h0001_0000);
    // R1 selector readback, unmapped words
    bus_read(5'h00, d); chk(d == 32'h3E, "R1 selector readback", d, 32'h3E);
    reg_write(8'h40, 32'hFFFF_FFFF);
    reg_read(8'h40, d); chk(d == 0, "R1 word past table", d, 0);
    reg_read(8'h05, d); chk(d == 0, "R1 gap word", d, 0);
    // R2 identifier
    reg_write(8'h00, 32'hA5FF_FFFF);
    reg_read(8'h00, d); chk(d == 32'hA500_0000, "R2 identifier", d, 32'hA500_0000);
    // R3 layout on line 5
    reg_write(8'h1B, 32'h22FF_FFFF);
    reg_write(8'h1A, lo(8'h41, DM_NONMSK, 1, 0, 0, 0) | 32'hFFFE_5000);
    reg_read(8'h1B, d); chk(d == 32'h2200_0000, "R3 high word", d, 32'h2200_0000);
    reg_read(8'h1A, d);
    chk(d == lo(8'h41, DM_NONMSK, 1, 0, 0, 0), "R3 low word", d, lo(8'h41, DM_NONMSK, 1, 0, 0, 0));
    // R6 / R11 edge message
    @(negedge clk); irq_in[5] = 1;
    cycles(2); irq_in[5] = 0;
    wait_valid(20);
    chk(msg_valid && msg_vector == 8'h41, "R11 vector", 32'(msg_vector), 32'h41);
    chk(msg_dmode == DM_NONMSK, "R11 delivery type", 32'(msg_dmode), 4);
    chk(msg_dstmode == 1 && msg_dest == 8'h22, "R11 destination", 32'(msg_dest), 32'h22);
    reg_read(8'h1A, d);
    chk(d[12] == 1, "R9 status while shown", 32'(d[12]), 1);
    accept();
    reg_read(8'h1A, d);
    chk(d[12] == 0, "R9 status after accept", 32'(d[12]), 0);
    @(negedge clk); irq_in[5] = 1;
    wait_valid(20); accept();
    cycles(8);
    chk(msg_valid === 0, "R6 held line sends once", 32'(msg_valid), 0);
    irq_in[5] = 0;
    // R10 priority
    reg_write(8'h16, lo(8'h33, DM_FIXED, 0, 0, 0, 0));
    reg_write(8'h22, lo(8'h99, DM_LOWPRI, 0, 0, 0, 0));
    @(negedge clk); irq_in[3] = 1; irq_in[9] = 1;
    wait_valid(20); cycles(3);
    chk(msg_vector == 8'h33, "R10 lowest line first", 32'(msg_vector), 32'h33);
    accept(); wait_valid(20);
    chk(msg_vector == 8'h99, "R10 second line next", 32'(msg_vector), 32'h99);
    accept();
    irq_in[3] = 0; irq_in[9] = 0;
    // R5 / R7 level, active low, line 7
    irq_in[7] = 1;
    reg_write(8'h1E, lo(8'h70, DM_EXTERN, 0, 1, 1, 0));
    cycles(5);
    chk(msg_valid === 0, "R5 high level inactive with pol 1", 32'(msg_valid), 0);
    irq_in[7] = 0;
    wait_valid(20);
    chk(msg_vector == 8'h70, "R5 low level active", 32'(msg_vector), 32'h70);
    accept(); cycles(6);
    chk(msg_valid === 0, "R7 hold blocks resend", 32'(msg_valid), 0);
    reg_read(8'h1E, d); chk(d[14] == 1, "R7 hold bit set", 32'(d[14]), 1);
    @(negedge clk); eoi_valid = 1; eoi_vector = 8'h71;
    @(negedge clk); eoi_valid = 0; cycles(4);
    chk(msg_valid === 0, "R7 other vector ignored", 32'(msg_valid), 0);
    @(negedge clk); eoi_valid = 1; eoi_vector = 8'h70;
    @(negedge clk); eoi_valid = 0;
    wait_valid(20);
    chk(msg_valid === 1, "R7 resend after eoi", 32'(msg_valid), 1);
    // same cycle: acceptance and eoi
    @(negedge clk); msg_ready = 1; eoi_valid = 1; eoi_vector = 8'h70;
    @(negedge clk); msg_ready = 0; eoi_valid = 0;
    cycles(6);
    chk(msg_valid === 0, "R7 accept wins over eoi", 32'(msg_valid), 0);
    reg_read(8'h1E, d); chk(d[14] == 1, "R7 hold after collision", 32'(d[14]), 1);
    irq_in[7] = 1;
    @(negedge clk); eoi_valid = 1;
    @(negedge clk); eoi_valid = 0; cycles(6);
    chk(msg_valid === 0, "R7 released line quiet", 32'(msg_valid), 0);
    // R8 masked line
    reg_write(8'h14, lo(8'h22, DM_FIXED, 0, 0, 0, 1));
    @(negedge clk); irq_in[2] = 1; cycles(2); irq_in[2] = 0;
    cycles(8);
    chk(msg_valid === 0, "R8 masked line silent", 32'(msg_valid), 0);
    // R8 mask withdraws a shown message
    reg_write(8'h18, lo(8'h44, DM_INIT, 0, 0, 0, 0));
    @(negedge clk); irq_in[4] = 1; cycles(2); irq_in[4] = 0;
    wait_valid(20);
    chk(msg_vector == 8'h44, "R8 line 4 shown", 32'(msg_vector), 32'h44);
    bus_write(5'h10, lo(8'h44, DM_INIT, 0, 0, 0, 1));
    cycles(3);
    chk(msg_valid === 0, "R8 withdrawn on mask", 32'(msg_valid), 0);
    // R12 read data holds
    reg_read(8'h18, d); cycles(3);
    chk(bus_rdata == d, "R12 read data holds", bus_rdata, d);
    cycles(4);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R10 act %0d exp %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule